// File: doc/BRIEF.md
# I2C Master Bit Sequencer

This block is the lowest layer of an I2C master. A byte-level controller hands it one command at a time: form a START condition, form a STOP condition, send one bit, or receive one bit. The block turns that command into the exact line activity on the open-drain SCL and SDA wires. It drives each wire through an output-enable, so that an asserted enable pulls the wire low. It reads both wires back through synchronisers. When the command is finished it raises a one-cycle completion pulse, together with the bit it sampled.

All timing comes from an enable tick at four times the SCL rate. The tick is produced by a 16-bit divider, which is loaded one byte at a time. Every command passes through four tick-timed phases. The phase that releases SCL waits until SCL actually reads high, so a slave can hold the clock low for as long as it needs. A separate detector watches the wires for START and STOP conditions from any master and keeps a bus-occupied flag.

Top module: `i2cm_bitseq`

## Requirements
- R1: The phase sequence advances only on the enable tick. The tick period is (divisor + 1) clock cycles. The divisor is {high byte, low byte}, and both bytes reset to 0xFF, so a command issued straight after reset does not finish within 1000 cycles.
- R2: A divisor byte write is taken only while `core_en` is 0. A write made while `core_en` is 1 leaves the tick period unchanged.
- R3: A START command (code 00) pulls SDA low while SCL is high. It finishes with both SCL and SDA driven low.
- R4: A START issued while SCL is held low by this block first releases SDA and then SCL. It then forms a new START without any STOP condition on the lines.
- R5: A STOP command (code 01) lets SDA rise while SCL is high. It finishes with both lines released.
- R6: A WRITE command (code 10) places `cmd_bit` on SDA while SCL is low and holds it through the SCL-high window. A 1 releases the line and a 0 drives it low.
- R7: A READ command (code 11) releases SDA. It returns on `rx_bit` the SDA level sampled while SCL is high.
- R8: While SCL is released but still reads low, the sequence does not advance and no completion is given.
- R9: `bus_busy` goes to 1 when a START condition is seen on the lines, from any master. It goes to 0 when a STOP condition is seen.
- R10: `done` is a single-cycle pulse, one per command. A command is accepted only when the block is idle and `core_en` is 1. A request made while a command is running is ignored.
- R11: After reset, both output enables are 0, and `done` and `bus_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| core_en | input | 1 | Enables the tick generator; divisor writes only when 0 |
| div_lo_we | input | 1 | Write strobe for the divisor low byte |
| div_hi_we | input | 1 | Write strobe for the divisor high byte |
| div_wdata | input | 8 | Divisor byte value |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 2 | 00 START, 01 STOP, 10 WRITE, 11 READ |
| cmd_bit | input | 1 | Bit to send for WRITE |
| done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Bit sampled by the last READ |
| bus_busy | output | 1 | Bus occupied flag |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Two events can land in the same cycle: the slave releasing a stretched SCL and the enable tick that would move the sequence out of its rise phase. The bench holds SCL low across many ticks and then lets it go. It judges the result by three things: no completion may appear during the hold, the bit sampled on the late rising edge must be correct, and the completion must follow the release. A second overlap is also exercised. A command request is made while another command is running, and the bench checks that it yields neither a second completion nor any line activity.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'b00,
    CMD_STOP  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_READ  = 2'b11
  } cmd_e;

  localparam int unsigned PHASES = 4;
  localparam int unsigned PH_W   = $clog2(PHASES);

  // returns {scl_oe, sda_oe} for a given command and phase (oe=1 pulls low)
  function automatic logic [1:0] phase_drive(cmd_e c, logic [PH_W-1:0] p,
                                             logic b, logic scl_now);
    logic [1:0] r;
    case (c)
      CMD_START: case (p)
        2'd0:    r = {scl_now, 1'b0};
        2'd1:    r = 2'b00;
        2'd2:    r = 2'b01;
        default: r = 2'b11;
      endcase
      CMD_STOP: case (p)
        2'd0:    r = 2'b11;
        2'd1:    r = 2'b01;
        2'd2:    r = 2'b01;
        default: r = 2'b00;
      endcase
      CMD_WRITE: case (p)
        2'd0:    r = {1'b1, ~b};
        2'd1:    r = {1'b0, ~b};
        2'd2:    r = {1'b0, ~b};
        default: r = {1'b1, ~b};
      endcase
      default: case (p)
        2'd0:    r = 2'b10;
        2'd1:    r = 2'b00;
        2'd2:    r = 2'b00;
        default: r = 2'b10;
      endcase
    endcase
    return r;
  endfunction
endpackage

// File: rtl/i2cm_tick_gen.sv
module i2cm_tick_gen #(
  parameter int unsigned PART_W = 8,
  localparam int unsigned DIV_W = 2 * PART_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_en,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [PART_W-1:0] wdata,
  output logic              tick,
  output logic [DIV_W-1:0]  div_q
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '1;
      cnt   <= '0;
      tick  <= 1'b0;
    end else if (!core_en) begin
      if (lo_we) div_q[PART_W-1:0]     <= wdata;
      if (hi_we) div_q[DIV_W-1:PART_W] <= wdata;
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == div_q) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_line_mon.sv
module i2cm_line_mon #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic bus_busy
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic sda_d, scl_d;
  logic start_seen, stop_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  assign start_seen = scl_s && scl_d && sda_d && !sda_s;
  assign stop_seen  = scl_s && scl_d && !sda_d && sda_s;

  always_ff @(posedge clk) begin
    if (rst)             bus_busy <= 1'b0;
    else if (start_seen) bus_busy <= 1'b1;
    else if (stop_seen)  bus_busy <= 1'b0;
  end
endmodule

// File: rtl/i2cm_bitseq.sv
module i2cm_bitseq
  import i2cm_pkg::*;
#(
  parameter int unsigned PART_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DIV_W      = 2 * PART_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_en,
  input  logic              div_lo_we,
  input  logic              div_hi_we,
  input  logic [PART_W-1:0] div_wdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic              cmd_bit,
  output logic              done,
  output logic              rx_bit,
  output logic              bus_busy,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic             tick;
  logic [DIV_W-1:0] div_q;
  logic             scl_s, sda_s;

  i2cm_tick_gen #(.PART_W(PART_W)) u_tick (
    .clk(clk), .rst(rst), .core_en(core_en),
    .lo_we(div_lo_we), .hi_we(div_hi_we), .wdata(div_wdata),
    .tick(tick), .div_q(div_q)
  );

  i2cm_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .bus_busy(bus_busy)
  );

  logic            act_q;
  logic [PH_W-1:0] ph_q;
  cmd_e            cmd_q;
  logic            bit_q;
  logic            accept, stall, step;
  logic [1:0]      drv_first, drv_next;

  assign accept = !act_q && cmd_valid && core_en;
  assign stall  = (ph_q == PH_W'(1)) && !scl_s;
  assign step   = act_q && tick && !stall;

  assign drv_first = phase_drive(cmd_e'(cmd_code), '0, cmd_bit, scl_oe);
  assign drv_next  = phase_drive(cmd_q, ph_q + 1'b1, bit_q, scl_oe);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      ph_q   <= '0;
      cmd_q  <= CMD_START;
      bit_q  <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      rx_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        act_q  <= 1'b1;
        ph_q   <= '0;
        cmd_q  <= cmd_e'(cmd_code);
        bit_q  <= cmd_bit;
        scl_oe <= drv_first[1];
        sda_oe <= drv_first[0];
      end else if (step) begin
        if (ph_q == PH_W'(PHASES - 1)) begin
          act_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          ph_q   <= ph_q + 1'b1;
          scl_oe <= drv_next[1];
          sda_oe <= drv_next[0];
          if (ph_q == PH_W'(2) && cmd_q == CMD_READ) rx_bit <= sda_s;
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_bitseq_chk.sv
module i2cm_bitseq_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             core_en,
  input logic             done,
  input logic             bus_busy,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             act_q,
  input logic [1:0]       ph_q,
  input logic [1:0]       cmd_q,
  input logic             tick,
  input logic             scl_s,
  input logic [DIV_W-1:0] div_q
);
  // R11
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!scl_oe && !sda_oe && !done && !bus_busy));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1
  tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && !tick) |=> (act_q && $stable(ph_q)));

  // R8
  stretch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && ph_q == 2'd1 && !scl_s) |=> (act_q && ph_q == 2'd1 && !done));

  // R2
  div_lock_chk: assert property (@(posedge clk) disable iff (rst)
    core_en |=> $stable(div_q));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && cmd_q[1] && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
endmodule

bind i2cm_bitseq i2cm_bitseq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .core_en(core_en), .done(done), .bus_busy(bus_busy),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .act_q(act_q), .ph_q(ph_q),
  .cmd_q(cmd_q), .tick(tick), .scl_s(scl_s), .div_q(div_q)
);

// File: tb/i2cm_bitseq_bench.sv
module i2cm_bitseq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_en = 1'b0, div_lo_we = 1'b0, div_hi_we = 1'b0;
  logic [7:0] div_wdata = '0;
  logic cmd_valid = 1'b0, cmd_bit = 1'b0;
  logic [1:0] cmd_code = 2'b00;
  logic done, rx_bit, bus_busy, scl_oe, sda_oe;
  logic slv_scl_hold = 1'b0, slv_sda_low = 1'b0, ext_sda_low = 1'b0;
  logic scl_ln, sda_ln;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int start_cnt = 0, stop_cnt = 0;
  logic cap_bit = 1'b0;

  always #5 clk = ~clk;

  assign scl_ln = ~scl_oe & ~slv_scl_hold;
  assign sda_ln = ~sda_oe & ~slv_sda_low & ~ext_sda_low;

  i2cm_bitseq u_i2cm_bitseq (
    .clk(clk), .rst(rst), .core_en(core_en), .div_lo_we(div_lo_we),
    .div_hi_we(div_hi_we), .div_wdata(div_wdata), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_bit(cmd_bit), .done(done), .rx_bit(rx_bit),
    .bus_busy(bus_busy), .scl_i(scl_ln), .sda_i(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(negedge sda_ln) if (scl_ln === 1'b1) start_cnt++;
  always @(posedge sda_ln) if (scl_ln === 1'b1) stop_cnt++;
  always @(posedge scl_ln) cap_bit = sda_ln;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_cmd(input logic [1:0] c, input logic b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_bit = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int max, output int n, output logic seen);
    seen = 1'b0; n = 0;
    while (!seen && n < max) begin
      @(negedge clk); n++;
      if (done) seen = 1'b1;
    end
    if (seen) begin
      @(negedge clk);
      chk(!done, "R10 done one cycle", done, 0);
    end
  endtask

  task automatic load_div(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk);
    core_en = 1'b0; div_wdata = lo; div_lo_we = 1'b1;
    @(negedge clk);
    div_lo_we = 1'b0; div_wdata = hi; div_hi_we = 1'b1;
    @(negedge clk);
    div_hi_we = 1'b0; core_en = 1'b1;
  endtask

  task automatic t_reset();
    chk(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
    chk(!done && !bus_busy, "R11 done/busy low", {done, bus_busy}, 0);
  endtask

  task automatic t_default_div();
    int n; logic seen;
    core_en = 1'b1;
    start_cmd(2'b00, 1'b0);
    wait_done(1000, n, seen);
    chk(!seen, "R1 default divisor slow", seen, 0);
    @(negedge clk); rst = 1'b1; core_en = 1'b0;
    idle(3); rst = 1'b0; idle(2);
    start_cnt = 0; stop_cnt = 0;
  endtask

  task automatic t_start();
    int n; logic seen;
    load_div(8'd3, 8'd0);
    start_cmd(2'b00, 1'b0);
    wait_done(200, n, seen);
    chk(seen && n >= 11 && n <= 20, "R1 start duration P=4", n, 16);
    chk(start_cnt == 1, "R3 start condition", start_cnt, 1);
    chk(scl_oe && sda_oe, "R3 lines low after start", {scl_oe, sda_oe}, 3);
    idle(5);
    chk(bus_busy, "R9 busy after own start", bus_busy, 1);
  endtask

  task automatic t_lock_and_write();
    int n; logic seen;
    @(negedge clk); div_wdata = 8'd15; div_lo_we = 1'b1;
    @(negedge clk); div_lo_we = 1'b0;
    start_cmd(2'b10, 1'b1);
    idle(3);
    cmd_valid = 1'b1; cmd_code = 2'b01; @(negedge clk); cmd_valid = 1'b0;
    wait_done(200, n, seen);
    chk(seen && n >= 9 && n <= 20, "R2 locked write ignored", n, 16);
    chk(cap_bit == 1'b1, "R6 write 1 sampled", cap_bit, 1);
    chk(!sda_oe, "R6 write 1 releases SDA", sda_oe, 0);
    idle(30);
    chk(stop_cnt == 0 && scl_oe, "R10 busy request ignored", stop_cnt, 0);
    load_div(8'd7, 8'd0);
    start_cmd(2'b10, 1'b0);
    wait_done(200, n, seen);
    chk(seen && n >= 23 && n <= 36, "R1 write duration P=8", n, 32);
    chk(cap_bit == 1'b0 && sda_oe, "R6 write 0 drives SDA", cap_bit, 0);
    chk(start_cnt == 1 && stop_cnt == 0, "R6 no conditions in data", start_cnt + stop_cnt, 1);
  endtask

  task automatic t_read();
    int n; logic seen;
    slv_sda_low = 1'b1;
    start_cmd(2'b11, 1'b0);
    wait_done(200, n, seen);
    chk(seen && rx_bit == 1'b0, "R7 read 0", rx_bit, 0);
    chk(!sda_oe, "R7 read releases SDA", sda_oe, 0);
    slv_sda_low = 1'b0;
    start_cmd(2'b11, 1'b0);
    wait_done(200, n, seen);
    chk(seen && rx_bit == 1'b1, "R7 read 1", rx_bit, 1);
  endtask

  task automatic t_stretch();
    int n; logic seen;
    slv_scl_hold = 1'b1;
    start_cmd(2'b10, 1'b0);
    wait_done(120, n, seen);
    chk(!seen, "R8 no done while stretched", seen, 0);
    chk(scl_ln == 1'b0, "R8 SCL held low", scl_ln, 0);
    slv_scl_hold = 1'b0;
    wait_done(100, n, seen);
    chk(seen, "R8 done after release", seen, 1);
    chk(cap_bit == 1'b0, "R8 bit after stretch", cap_bit, 0);
  endtask

  task automatic t_rstart();
    int n; logic seen;
    start_cmd(2'b00, 1'b0);
    wait_done(200, n, seen);
    chk(seen && start_cnt == 2, "R4 repeated start seen", start_cnt, 2);
    chk(stop_cnt == 0, "R4 no stop before restart", stop_cnt, 0);
  endtask

  task automatic t_stop();
    int n; logic seen;
    start_cmd(2'b01, 1'b0);
    wait_done(200, n, seen);
    chk(seen && stop_cnt == 1, "R5 stop condition", stop_cnt, 1);
    chk(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
    idle(5);
    chk(!bus_busy, "R9 busy cleared by stop", bus_busy, 0);
  endtask

  task automatic t_ext_busy();
    idle(4);
    ext_sda_low = 1'b1; idle(6);
    chk(bus_busy, "R9 busy on foreign start", bus_busy, 1);
    ext_sda_low = 1'b0; idle(6);
    chk(!bus_busy, "R9 idle on foreign stop", bus_busy, 0);
  endtask

  initial begin
    idle(3); rst = 1'b0; idle(1);
    start_cnt = 0; stop_cnt = 0;
    t_reset();
    t_default_div();
    t_start();
    t_lock_and_write();
    t_read();
    t_stretch();
    t_rstart();
    t_stop();
    t_ext_busy();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule